// File: doc/BRIEF.md
# Shared Mailbox Request Engine

This block runs the requesting side of a 256-bit shared mailbox. The mailbox is organised as eight 32-bit dwords, and the last dword carries the control header. A single start pulse launches one of two operations. The first is an establish request. It carries four page-aligned queue base addresses and a 16-bit interrupt vector number. The second is a teardown request, which carries only a header.

The engine works through four steps:
- It polls the ownership bit of the header dword until the requester side owns the mailbox.
- It writes the message one dword per cycle, with the header dword last.
- It polls again until ownership comes back.
- It validates the response header.

Each operation ends with a one-cycle `done` pulse. The `err` and `tmo` flags are held until the next accepted start. The spacing between polls is set by a programmable gap counter. The number of polls is bounded by a parameter.

The mailbox storage is outside the block. Writes leave through a dword-indexed write port. The current header dword is presented on `mb_hdr_in`, and the engine samples it on every poll.

Top module: `mbox_req_engine`

## Requirements
- R1: In an establish message, frame number i (address >> PAGE_SHIFT, 52 bits wide) has its low 48 bits at bytes 6i..6i+5, little-endian. The order is i=0 EQ, 1 CQ, 2 RQ, 3 SQ, so bytes 0–23 fill dwords 0–5.
- R2: In an establish message, dword 6 bits [15:0] hold the top 4 bits of each frame, with frame i at bits [4i+3:4i]. Dword 6 bits [31:16] hold the vector number.
- R3: Dwords are written one per cycle in the order 0,1,…,7. The header (dword 7) is always the last write. A teardown writes dword 7 only.
- R4: The request header has the type in bits [2:0] (1 for establish, 2 for teardown), the version in bits [5:3] (0), bit 7 = 0 (request), and bits [15:8] = 0. Bit 24 carries the reset-request flag. Bit 31 is 0, and all other bits are 0.
- R5: No write occurs until a poll sees `mb_hdr_in[31]` = 0. After each failed poll, the engine idles `poll_gap` cycles before the next poll.
- R6: A response, taken when bit 31 reads 0, succeeds only if bits [2:0] equal the request type, bits [5:3] are at most the request version, bit 7 = 1, and bits [15:8] = 0. Completion gives one `done` pulse, with `err` = 1 on a failed check.
- R7: When the reset flag was requested, a response poll reading 0xFFFFFFFF completes with `err` = 0. No field check is made in that case.
- R8: After MAX_POLLS consecutive polls that see bit 31 = 1 in either polling phase, the engine stops with `done` and `tmo` = 1 and `err` = 0.
- R9: `start` has no effect while `busy` is 1.
- R10: An establish start with any address not aligned to 2^PAGE_SHIFT, or with `vec_idx` above 0xFFFF, gives `done` and `err` in the next cycle without any mailbox write. Teardown ignores these inputs.
- R11: After reset, `busy`, `done`, `err`, `tmo` and `mb_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one operation when idle |
| op_down | input | 1 | 0 = establish, 1 = teardown |
| reset_req | input | 1 | Reset-request flag placed in the header |
| eq_addr | input | 64 | Event queue base address |
| cq_addr | input | 64 | Completion queue base address |
| rq_addr | input | 64 | Receive queue base address |
| sq_addr | input | 64 | Send queue base address |
| vec_idx | input | 32 | Interrupt vector number |
| poll_gap | input | GAP_W | Idle cycles between polls |
| mb_hdr_in | input | 32 | Current value of the mailbox header dword |
| mb_wr_en | output | 1 | Mailbox dword write strobe |
| mb_wr_idx | output | 3 | Dword index of the write |
| mb_wr_data | output | 32 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Input or response error of the last operation |
| tmo | output | 1 | Last operation timed out |

## Verification
Some properties are checked on every cycle:
- Writes occur only while busy, and the dword index steps by one.
- The header is the final write and has request-shaped fields.
- The first write follows a poll that saw ownership free.
- Busy only drops with a `done` pulse, and `err` and `tmo` are never both set.

Other behaviour needs the bench's scenarios:
- The exact byte placement of frames, nibbles and the vector.
- Acceptance or rejection of each response field combination.
- The reset-mode all-ones shortcut.
- The timeout counts and the gap spacing.
- Rejection of bad inputs, and ignoring `start` while busy.

// File: rtl/mbox_req_engine.sv
`timescale 1ns/1ps
module mbox_req_engine #(
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_POLLS  = 20000,
  parameter int GAP_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_down,
  input  logic              reset_req,
  input  logic [63:0]       eq_addr,
  input  logic [63:0]       cq_addr,
  input  logic [63:0]       rq_addr,
  input  logic [63:0]       sq_addr,
  input  logic [31:0]       vec_idx,
  input  logic [GAP_W-1:0]  poll_gap,
  input  logic [31:0]       mb_hdr_in,
  output logic              mb_wr_en,
  output logic [2:0]        mb_wr_idx,
  output logic [31:0]       mb_wr_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              tmo
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int FW = 52;
  localparam logic [2:0] REQ_VER = 3'd0;

  typedef enum logic [2:0] {S_IDLE, S_OWN, S_OWN_GAP, S_WR, S_RSP, S_RSP_GAP} st_t;
  st_t st;

  logic [255:0]     msg;
  logic [2:0]       idx;
  logic [PW-1:0]    polls;
  logic [GAP_W-1:0] gap;
  logic             down_q, rst_q;

  function automatic logic [FW-1:0] frame(input logic [63:0] a);
    return FW'(a >> PAGE_SHIFT);
  endfunction

  function automatic logic misal(input logic [63:0] a);
    return |a[PAGE_SHIFT-1:0];
  endfunction

  wire [FW-1:0] f0 = frame(eq_addr);
  wire [FW-1:0] f1 = frame(cq_addr);
  wire [FW-1:0] f2 = frame(rq_addr);
  wire [FW-1:0] f3 = frame(sq_addr);

  wire [31:0] hdr_req = {7'd0, reset_req, 16'd0, 5'd0, op_down ? 3'd2 : 3'd1};

  wire [255:0] est_msg = {hdr_req, vec_idx[15:0],
                          f3[51:48], f2[51:48], f1[51:48], f0[51:48],
                          f3[47:0], f2[47:0], f1[47:0], f0[47:0]};

  wire bad_in = !op_down &&
                (misal(eq_addr) || misal(cq_addr) || misal(rq_addr) || misal(sq_addr) ||
                 (|vec_idx[31:16]));

  wire own_free = !mb_hdr_in[31];
  wire all_ones = &mb_hdr_in;
  wire rsp_ok   = (mb_hdr_in[2:0] == (down_q ? 3'd2 : 3'd1)) &&
                  !(mb_hdr_in[5:3] > REQ_VER) &&
                  mb_hdr_in[7] && (mb_hdr_in[15:8] == 8'd0);
  wire last_try = (polls == PW'(MAX_POLLS - 1));
  wire in_rsp   = (st == S_RSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      msg    <= '0;
      idx    <= '0;
      polls  <= '0;
      gap    <= '0;
      down_q <= 1'b0;
      rst_q  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      tmo    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err <= 1'b0;
          tmo <= 1'b0;
          if (bad_in) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            msg    <= op_down ? {hdr_req, 224'd0} : est_msg;
            down_q <= op_down;
            rst_q  <= reset_req;
            polls  <= '0;
            st     <= S_OWN;
          end
        end
        S_OWN, S_RSP: begin
          if (in_rsp && rst_q && all_ones) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (own_free) begin
            if (in_rsp) begin
              done <= 1'b1;
              err  <= !rsp_ok;
              st   <= S_IDLE;
            end else begin
              idx <= down_q ? 3'd7 : 3'd0;
              st  <= S_WR;
            end
          end else if (last_try) begin
            done <= 1'b1;
            tmo  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
            if (poll_gap != '0) begin
              gap <= poll_gap;
              st  <= in_rsp ? S_RSP_GAP : S_OWN_GAP;
            end
          end
        end
        S_OWN_GAP, S_RSP_GAP: begin
          if (gap == GAP_W'(1)) st <= (st == S_OWN_GAP) ? S_OWN : S_RSP;
          else gap <= gap - 1'b1;
        end
        S_WR: begin
          if (idx == 3'd7) begin
            polls <= '0;
            st    <= S_RSP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign mb_wr_en   = (st == S_WR);
  assign mb_wr_idx  = idx;
  assign mb_wr_data = msg[{idx, 5'd0} +: 32];
endmodule

// File: rtl/mbox_req_chk.sv
`timescale 1ns/1ps
module mbox_req_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        own_bit,
  input logic        mb_wr_en,
  input logic [2:0]  mb_wr_idx,
  input logic [6:0]  wd_hi,
  input logic [23:0] wd_lo,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        tmo
);
  p_wr_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr_en |-> busy);

  p_hdr_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr_en && mb_wr_idx == 3'd7) |=> !mb_wr_en);

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr_en && mb_wr_idx != 3'd7) |=> (mb_wr_en && mb_wr_idx == $past(mb_wr_idx) + 3'd1));

  p_hdr_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr_en && mb_wr_idx == 3'd7) |->
      (wd_hi == 7'd0 && wd_lo[23:3] == 21'd0 && (wd_lo[2:0] == 3'd1 || wd_lo[2:0] == 3'd2)));

  p_own_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mb_wr_en) |-> ($past(own_bit) == 1'b0));

  p_end_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && tmo));
endmodule

bind mbox_req_engine mbox_req_chk u_chk (
  .clk(clk), .rst_n(rst_n), .own_bit(mb_hdr_in[31]),
  .mb_wr_en(mb_wr_en), .mb_wr_idx(mb_wr_idx),
  .wd_hi(mb_wr_data[31:25]), .wd_lo(mb_wr_data[23:0]),
  .busy(busy), .done(done), .err(err), .tmo(tmo)
);

// File: tb/sim_mbox_req_engine.sv
`timescale 1ns/1ps
module sim_mbox_req_engine;
  localparam int MP = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, op_down = 1'b0, reset_req = 1'b0;
  logic [63:0] eq_addr = '0, cq_addr = '0, rq_addr = '0, sq_addr = '0;
  logic [31:0] vec_idx = '0;
  logic [15:0] poll_gap = '0;
  logic [31:0] mem [8];
  logic [31:0] mb_hdr_in;
  logic        mb_wr_en, busy, done, err, tmo;
  logic [2:0]  mb_wr_idx;
  logic [31:0] mb_wr_data;

  assign mb_hdr_in = mem[7];

  mbox_req_engine #(.MAX_POLLS(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_down(op_down), .reset_req(reset_req),
    .eq_addr(eq_addr), .cq_addr(cq_addr), .rq_addr(rq_addr), .sq_addr(sq_addr),
    .vec_idx(vec_idx), .poll_gap(poll_gap), .mb_hdr_in(mb_hdr_in),
    .mb_wr_en(mb_wr_en), .mb_wr_idx(mb_wr_idx), .mb_wr_data(mb_wr_data),
    .busy(busy), .done(done), .err(err), .tmo(tmo));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mailbox and responder side
  int rel_cnt = 0, pf_delay = 0, wr_count = 0;
  logic [31:0] rel_val = '0, pf_resp = '0, hdr_seen = '0;
  initial for (int i = 0; i < 8; i++) mem[i] = '0;
  always @(negedge clk) begin
    if (rel_cnt > 0) begin
      rel_cnt--;
      if (rel_cnt == 0) mem[7] = rel_val;
    end
    if (mb_wr_en) begin
      wr_count++;
      mem[mb_wr_idx] = mb_wr_data;
      if (mb_wr_idx == 3'd7) begin
        hdr_seen = mb_wr_data;
        mem[7] = mb_wr_data | 32'h8000_0000;
        if (pf_delay > 0) begin
          rel_cnt = pf_delay;
          rel_val = pf_resp;
        end
      end
    end
  end

  // packing from the requirements, byte by byte
  function automatic logic [255:0] pack(input bit dn, input bit rr, input logic [63:0] e,
      input logic [63:0] c, input logic [63:0] r, input logic [63:0] s, input logic [31:0] v);
    logic [7:0]  b [32];
    logic [63:0] f [4];
    logic [15:0] hi;
    logic [255:0] m;
    f[0] = e >> 12; f[1] = c >> 12; f[2] = r >> 12; f[3] = s >> 12;
    hi = '0;
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 6; k++) b[6*i+k] = f[i][8*k +: 8];
      hi = hi | (16'(f[i][51:48]) << (4*i));
    end
    b[24] = hi[7:0]; b[25] = hi[15:8]; b[26] = v[7:0]; b[27] = v[15:8];
    b[28] = dn ? 8'd2 : 8'd1; b[29] = 8'd0; b[30] = 8'd0; b[31] = {7'd0, rr};
    for (int i = 0; i < 32; i++) m[8*i +: 8] = b[i];
    return m;
  endfunction

  function automatic bit resp_good(input logic [31:0] h, input bit dn);
    return (h[2:0] == (dn ? 3'd2 : 3'd1)) && (h[5:3] <= 3'd0) && h[7] && (h[15:8] == 8'd0);
  endfunction

  // behavioural reference model
  int ph = 0, mpolls = 0, mgap = 0;
  bit m_done = 0, m_err = 0, m_tmo = 0, m_wr = 0, m_dn = 0, m_rr = 0;
  logic [34:0] m_cur = '0;
  logic [34:0] q [$];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_done = 0; m_err = 0; m_tmo = 0; m_wr = 0; q.delete();
    end else begin
      m_done = 0;
      case (ph)
        0: if (start) begin
          m_err = 0; m_tmo = 0;
          if (!op_down && ((eq_addr[11:0] != 0) || (cq_addr[11:0] != 0) || (rq_addr[11:0] != 0) ||
                           (sq_addr[11:0] != 0) || (vec_idx > 32'hFFFF))) begin
            m_done = 1; m_err = 1;
          end else begin
            logic [255:0] mm;
            mm = pack(op_down, reset_req, eq_addr, cq_addr, rq_addr, sq_addr, vec_idx);
            q.delete();
            if (op_down) q.push_back({3'd7, mm[255:224]});
            else for (int d = 0; d < 8; d++) q.push_back({3'(d), mm[32*d +: 32]});
            m_dn = op_down; m_rr = reset_req; mpolls = 0; ph = 1;
          end
        end
        1, 4: begin
          if (ph == 4 && m_rr && mb_hdr_in == 32'hFFFF_FFFF) begin
            m_done = 1; ph = 0;
          end else if (!mb_hdr_in[31]) begin
            if (ph == 1) begin
              m_cur = q.pop_front(); m_wr = 1; ph = 3;
            end else begin
              m_done = 1; m_err = !resp_good(mb_hdr_in, m_dn); ph = 0;
            end
          end else begin
            mpolls++;
            if (mpolls == MP) begin
              m_done = 1; m_tmo = 1; ph = 0;
            end else if (poll_gap != 0) begin
              mgap = int'(poll_gap); ph = ph + 1;
            end
          end
        end
        2, 5: begin
          mgap--;
          if (mgap == 0) ph = ph - 1;
        end
        3: begin
          if (q.size() == 0) begin
            m_wr = 0; ph = 4; mpolls = 0;
          end else m_cur = q.pop_front();
        end
        default: ph = 0;
      endcase
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(busy == (ph != 0), "R9 busy per cycle", 64'(busy), 64'(ph != 0));
      chk(done == m_done, "R6 done per cycle", 64'(done), 64'(m_done));
      chk(err == m_err, "R6 err per cycle", 64'(err), 64'(m_err));
      chk(tmo == m_tmo, "R8 tmo per cycle", 64'(tmo), 64'(m_tmo));
      chk(mb_wr_en == m_wr, "R5 write strobe per cycle", 64'(mb_wr_en), 64'(m_wr));
      if (m_wr && mb_wr_en) begin
        chk(mb_wr_idx == m_cur[34:32], "R3 write index", 64'(mb_wr_idx), 64'(m_cur[34:32]));
        chk(mb_wr_data == m_cur[31:0], "R1 write data", 64'(mb_wr_data), 64'(m_cur[31:0]));
      end
    end
  end

  task automatic run_op(input bit dn, input bit rr, input logic [63:0] e, input logic [63:0] c,
      input logic [63:0] r, input logic [63:0] s, input logic [31:0] v,
      input logic [31:0] pre7, input int pre_rel, input logic [31:0] pre_val,
      input int dly, input logic [31:0] resp, input logic [15:0] gapv, input bit poke);
    bit got;
    int k;
    @(posedge clk); #2;
    op_down = dn; reset_req = rr; eq_addr = e; cq_addr = c; rq_addr = r; sq_addr = s;
    vec_idx = v; poll_gap = gapv; mem[7] = pre7; rel_cnt = pre_rel; rel_val = pre_val;
    pf_delay = dly; pf_resp = resp; wr_count = 0; hdr_seen = '0;
    @(posedge clk); #2;
    start = 1'b1;
    @(posedge clk); #1;
    got = done;
    #1 start = 1'b0;
    if (poke && !got) begin
      repeat (2) @(posedge clk);
      #2;
      op_down = ~dn; eq_addr = 64'h123; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
    end
    k = 0;
    while (!got && k < 3000) begin
      @(posedge clk); #1;
      got = done;
      k++;
    end
    chk(got, "R6 operation completes", 64'(got), 64'd1);
  endtask

  localparam logic [63:0] A_EQ = 64'hA000_0000_0000_1000;
  localparam logic [63:0] A_CQ = 64'h3123_4567_89AB_C000;
  localparam logic [63:0] A_RQ = 64'h5000_0000_0FED_0000;
  localparam logic [63:0] A_SQ = 64'hC00F_0000_0000_2000;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] em;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    chk({busy, done, err, tmo, mb_wr_en} == 5'b0, "R11 reset outputs",
        64'({busy, done, err, tmo, mb_wr_en}), 64'd0);

    // establish, good response, gap 2
    run_op(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0000_BEEF, 32'h0, 0, 0, 3, 32'h0000_0081, 16'd2, 0);
    chk(err == 0 && tmo == 0, "R6 valid establish response", 64'({err, tmo}), 64'd0);
    chk(mem[0] == 32'h0000_0001, "R1 dword0", 64'(mem[0]), 64'h1);
    chk(mem[1] == 32'h9ABC_0000, "R1 dword1", 64'(mem[1]), 64'h9ABC0000);
    chk(mem[6] == 32'hBEEF_C53A, "R2 nibbles and vector", 64'(mem[6]), 64'hBEEFC53A);
    em = pack(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0000_BEEF);
    for (int d = 0; d < 7; d++) chk(mem[d] == em[32*d +: 32], "R1 packed dword", 64'(mem[d]), 64'(em[32*d +: 32]));
    chk(wr_count == 8, "R3 establish write count", 64'(wr_count), 64'd8);
    chk(hdr_seen == 32'h0000_0001, "R4 establish header", 64'(hdr_seen), 64'h1);

    // pre-owned mailbox, reset mode, all-ones reply, no gap
    run_op(0, 1, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0000_0007, 32'h8000_0000, 5, 32'h0, 3, 32'hFFFF_FFFF, 16'd0, 0);
    chk(err == 0 && tmo == 0, "R7 all ones in reset mode", 64'({err, tmo}), 64'd0);
    chk(hdr_seen == 32'h0100_0001, "R4 reset flag in header", 64'(hdr_seen), 64'h01000001);

    // teardown with nonzero status
    run_op(1, 0, 64'h0, 64'h0, 64'h0, 64'h0, 32'h0, 32'h0, 0, 0, 2, 32'h0000_0182, 16'd1, 0);
    chk(err == 1, "R6 nonzero status rejected", 64'(err), 64'd1);
    chk(wr_count == 1, "R3 teardown writes header only", 64'(wr_count), 64'd1);
    chk(hdr_seen == 32'h0000_0002, "R4 teardown header", 64'(hdr_seen), 64'h2);

    // teardown good; misaligned address ignored in teardown (R10)
    run_op(1, 1, 64'h7, 64'h0, 64'h0, 64'h0, 32'h1_0000, 32'h0, 0, 0, 4, 32'h0000_0082, 16'd3, 0);
    chk(err == 0 && tmo == 0, "R10 teardown ignores address and vector", 64'({err, tmo}), 64'd0);

    // response field errors
    run_op(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h1, 32'h0, 0, 0, 2, 32'h0000_0089, 16'd1, 0);
    chk(err == 1, "R6 newer version rejected", 64'(err), 64'd1);
    run_op(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h1, 32'h0, 0, 0, 2, 32'h0000_0082, 16'd1, 0);
    chk(err == 1, "R6 type mismatch rejected", 64'(err), 64'd1);
    run_op(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h1, 32'h0, 0, 0, 2, 32'h0000_0001, 16'd1, 0);
    chk(err == 1, "R6 request direction rejected", 64'(err), 64'd1);

    // all ones without reset mode keeps owner bit set: timeout
    run_op(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h1, 32'h0, 0, 0, 2, 32'hFFFF_FFFF, 16'd2, 0);
    chk(tmo == 1 && err == 0, "R8 response timeout", 64'({tmo, err}), 64'h2);

    // never owned before writing: timeout, no writes
    run_op(1, 0, 64'h0, 64'h0, 64'h0, 64'h0, 32'h0, 32'h8000_0000, 0, 0, 2, 32'h0, 16'd1, 0);
    chk(tmo == 1, "R8 ownership timeout", 64'(tmo), 64'd1);
    chk(wr_count == 0, "R5 no write before ownership", 64'(wr_count), 64'd0);

    // bad inputs
    run_op(0, 0, A_EQ, A_CQ | 64'h800, A_RQ, A_SQ, 32'h1, 32'h0, 0, 0, 2, 32'h81, 16'd1, 0);
    chk(err == 1 && wr_count == 0, "R10 misaligned address", 64'({err, 8'(wr_count)}), 64'h100);
    run_op(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h1_0000, 32'h0, 0, 0, 2, 32'h81, 16'd1, 0);
    chk(err == 1 && wr_count == 0, "R10 oversized vector", 64'({err, 8'(wr_count)}), 64'h100);

    // start while busy is ignored
    run_op(0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0000_1234, 32'h0, 0, 0, 6, 32'h0000_0081, 16'd2, 1);
    chk(err == 0 && wr_count == 8, "R9 start ignored while busy", 64'({err, 8'(wr_count)}), 64'h8);
    repeat (5) @(posedge clk);
    #1 chk(busy == 0, "R9 no second operation", 64'(busy), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule